// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the responses of a circuit under test during built-in self-test. On every clock where capture is enabled, it folds one parallel response word into a running signature. The structure is a shift register with linear feedback, and every stage also mixes in its own response bit. The final signature therefore depends on the whole sequence of responses, not only on the most recent word.

When the test ends, the controller pulses `done`. The block compares the signature held during that cycle with the golden value. One cycle later it raises either `pass` or `fail`. The verdict then stays fixed, and the signature is frozen, until reset or a new seed load.

The compaction is lossy. A faulty response stream can land on the golden signature (aliasing), and the compare cannot tell that case apart from a good run. A build option replaces every XOR of the update with XNOR.

Top module: `misr_compactor`

## Requirements
- R1: While `rst_n` is low, and after it is released, `signature` is all zeros and both `pass` and `fail` are 0.
- R2: `seed_load` high loads `seed_val` into `signature` on the next edge and clears `pass` and `fail`. It takes priority over `cap_en` and `done` in the same cycle.
- R3: With `cap_en` high and no verdict set, the new stage 0 equals `resp[0]` XOR the parity of (`signature` AND `TAP_MASK`). The default `TAP_MASK` is 16'hB400 (bits 15, 13, 12, 10), which corresponds to x^16+x^14+x^13+x^11+1.
- R4: With `cap_en` high and no verdict set, each new stage i>0 equals old stage i-1 XOR `resp[i]`.
- R5: With `INVERT`=1 (XNOR build), every new stage value from R3 and R4 is complemented.
- R6: With `cap_en` and `seed_load` low, `signature` holds its value whatever `resp` does.
- R7: A `done` pulse while no verdict is set makes `pass`=1 on the next cycle if `signature` equalled `golden` during the `done` cycle. Otherwise it makes `fail`=1. The two flags are never high together.
- R8: Once a verdict is set, it holds until reset or `seed_load`. Further `done` pulses, `golden` changes and `cap_en` have no effect, and `signature` stays frozen.
- R9: The same seed and the same response sequence always give the same signature. A single flipped response bit anywhere in the sequence gives a different final signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seed_load | input | 1 | Load `seed_val` and clear the verdict |
| seed_val | input | WIDTH | Starting signature |
| cap_en | input | 1 | Fold `resp` into the signature this cycle |
| resp | input | WIDTH | Parallel response word from the circuit under test |
| golden | input | WIDTH | Expected final signature |
| done | input | 1 | End-of-test strobe |
| signature | output | WIDTH | Current signature |
| pass | output | 1 | Signature matched `golden` at `done` |
| fail | output | 1 | Signature differed from `golden` at `done` |

## Verification
The bench builds two instances side by side. The first is the default 16-bit XOR build with mask 16'hB400. The second is an 8-bit XNOR build with mask 8'hB8, which reaches the complemented update path and a second, shorter feedback polynomial. Both instances are compared word by word against an independent model of the update equations over a pseudo-random response stream. The same stream is then replayed clean and with one bit flipped, to show repeatability and fault sensitivity on both verdict outcomes.

// File: rtl/misr_pkg.sv
package misr_pkg;
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'b00,
    VERDICT_PASS = 2'b01,
    VERDICT_FAIL = 2'b10
  } verdict_e;
endpackage

// File: rtl/misr_feedback.sv
module misr_feedback #(
  parameter int                WIDTH    = 16,
  parameter logic [WIDTH-1:0]  TAP_MASK = 16'hB400
) (
  input  logic [WIDTH-1:0] state_i,
  output logic             fb_o
);
  localparam int NTAP = $countones(TAP_MASK);

  logic [WIDTH-1:0] tapped;

  // Only masked stages contribute to the parity.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
      if (TAP_MASK[i]) begin : g_on
        assign tapped[i] = state_i[i];
      end else begin : g_off
        assign tapped[i] = 1'b0;
      end
    end
  endgenerate

  generate
    if (NTAP == 0) begin : g_none
      assign fb_o = 1'b0;
    end else begin : g_par
      assign fb_o = ^tapped;
    end
  endgenerate
endmodule

// File: rtl/misr_next.sv
module misr_next #(
  parameter int WIDTH  = 16,
  parameter bit INVERT = 1'b0
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] resp_i,
  input  logic             fb_i,
  output logic [WIDTH-1:0] next_o
);
  logic [WIDTH-1:0] shifted;

  // Stage 0 takes the feedback; every other stage takes its predecessor.
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        assign shifted[i] = fb_i;
      end else begin : g_body
        assign shifted[i] = state_i[i-1];
      end
      if (INVERT) begin : g_xnor
        assign next_o[i] = ~(shifted[i] ^ resp_i[i]);
      end else begin : g_xor
        assign next_o[i] = shifted[i] ^ resp_i[i];
      end
    end
  endgenerate
endmodule

// File: rtl/misr_sig_reg.sv
module misr_sig_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load_i,
  input  logic [WIDTH-1:0] seed_val_i,
  input  logic             upd_en_i,
  input  logic [WIDTH-1:0] next_i,
  output logic [WIDTH-1:0] sig_o
);
  logic [WIDTH-1:0] sig_q;
  logic [WIDTH-1:0] sig_d;
  logic             sig_en;

  always_comb begin
    sig_en = seed_load_i | upd_en_i;
    if (seed_load_i) sig_d = seed_val_i;
    else             sig_d = next_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sig_q <= '0;
    else if (sig_en) sig_q <= sig_d;
  end

  assign sig_o = sig_q;
endmodule

// File: rtl/misr_verdict.sv
module misr_verdict
  import misr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load_i,
  input  logic             done_i,
  input  logic [WIDTH-1:0] sig_i,
  input  logic [WIDTH-1:0] golden_i,
  output logic             frozen_o,
  output logic             pass_o,
  output logic             fail_o
);
  verdict_e verdict_q;
  verdict_e verdict_d;
  logic     verdict_en;
  logic     match;

  always_comb begin
    match      = (sig_i == golden_i);
    verdict_en = 1'b0;
    verdict_d  = verdict_q;
    if (seed_load_i) begin
      verdict_en = 1'b1;
      verdict_d  = VERDICT_NONE;
    end else if (done_i && (verdict_q == VERDICT_NONE)) begin
      verdict_en = 1'b1;
      verdict_d  = match ? VERDICT_PASS : VERDICT_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          verdict_q <= VERDICT_NONE;
    else if (verdict_en) verdict_q <= verdict_d;
  end

  assign frozen_o = (verdict_q != VERDICT_NONE);
  assign pass_o   = (verdict_q == VERDICT_PASS);
  assign fail_o   = (verdict_q == VERDICT_FAIL);
endmodule

// File: rtl/misr_compactor.sv
module misr_compactor #(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
  parameter bit               INVERT   = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic [WIDTH-1:0] seed_val,
  input  logic             cap_en,
  input  logic [WIDTH-1:0] resp,
  input  logic [WIDTH-1:0] golden,
  input  logic             done,
  output logic [WIDTH-1:0] signature,
  output logic             pass,
  output logic             fail
);
  logic             fb;
  logic [WIDTH-1:0] sig_next;
  logic             frozen;
  logic             upd_en;

  assign upd_en = cap_en & ~frozen;

  misr_feedback #(.WIDTH(WIDTH), .TAP_MASK(TAP_MASK)) u_fb (
    .state_i (signature),
    .fb_o    (fb)
  );

  misr_next #(.WIDTH(WIDTH), .INVERT(INVERT)) u_next (
    .state_i (signature),
    .resp_i  (resp),
    .fb_i    (fb),
    .next_o  (sig_next)
  );

  misr_sig_reg #(.WIDTH(WIDTH)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_load_i (seed_load),
    .seed_val_i  (seed_val),
    .upd_en_i    (upd_en),
    .next_i      (sig_next),
    .sig_o       (signature)
  );

  misr_verdict #(.WIDTH(WIDTH)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .seed_load_i (seed_load),
    .done_i      (done),
    .sig_i       (signature),
    .golden_i    (golden),
    .frozen_o    (frozen),
    .pass_o      (pass),
    .fail_o      (fail)
  );
endmodule

// File: rtl/misr_compactor_chk.sv
module misr_compactor_chk #(
  parameter int               WIDTH    = 16,
  parameter logic [WIDTH-1:0] TAP_MASK = 16'hB400,
  parameter bit               INVERT   = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             seed_load,
  input logic [WIDTH-1:0] seed_val,
  input logic             cap_en,
  input logic [WIDTH-1:0] resp,
  input logic [WIDTH-1:0] golden,
  input logic             done,
  input logic [WIDTH-1:0] signature,
  input logic             pass,
  input logic             fail
);
  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (signature == $past(seed_val)) && !pass && !fail);

  // R3
  head_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !seed_load && !pass && !fail) |=>
      signature[0] == ($past(^(signature & TAP_MASK)) ^ $past(resp[0]) ^ INVERT));

  // R4
  body_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_en && !seed_load && !pass && !fail) |=>
      signature[WIDTH-1:1] == ($past(signature[WIDTH-2:0]) ^ $past(resp[WIDTH-1:1])
                               ^ {(WIDTH-1){INVERT}}));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !seed_load) |=> $stable(signature));

  // R7
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !seed_load && !pass && !fail) |=>
      (pass == ($past(signature) == $past(golden))) && (pass != fail));

  // R7
  exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  // R8
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pass && !seed_load) |=> pass);

  // R8
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !seed_load) |=> fail);

  // R8
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pass || fail) && !seed_load) |=> $stable(signature));
endmodule

bind misr_compactor misr_compactor_chk #(
  .WIDTH(WIDTH), .TAP_MASK(TAP_MASK), .INVERT(INVERT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
  .cap_en(cap_en), .resp(resp), .golden(golden), .done(done),
  .signature(signature), .pass(pass), .fail(fail)
);

// File: tb/tb_misr_compactor.sv
module tb_misr_compactor;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        seed_load, cap_en, done;
  logic [15:0] seed_val, resp, golden, sig16;
  logic [7:0]  seed_val8, resp8, golden8, sig8;
  logic        pass16, fail16, pass8, fail8;

  logic [15:0] m16;
  logic [7:0]  m8;
  logic [31:0] lcg;
  int n_checks = 0;
  int n_fails  = 0;

  misr_compactor dut (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val),
    .cap_en(cap_en), .resp(resp), .golden(golden), .done(done),
    .signature(sig16), .pass(pass16), .fail(fail16)
  );

  misr_compactor #(.WIDTH(8), .TAP_MASK(8'hB8), .INVERT(1'b1)) dut8 (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_val(seed_val8),
    .cap_en(cap_en), .resp(resp8), .golden(golden8), .done(done),
    .signature(sig8), .pass(pass8), .fail(fail8)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] ref_next(logic [15:0] s, logic [15:0] d,
                                           logic [15:0] mask, logic inv, int w);
    logic [15:0] n;
    n = '0;
    n[0] = (^(s & mask)) ^ d[0] ^ inv;
    for (int i = 1; i < w; i++) n[i] = s[i-1] ^ d[i] ^ inv;
    return n;
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // One capture cycle on both instances; model advanced alongside.
  task automatic capture(logic [15:0] d);
    logic [15:0] t;
    cap_en = 1'b1;
    resp   = d;
    resp8  = d[7:0] ^ d[15:8];
    m16    = ref_next(m16, d, 16'hB400, 1'b0, 16);
    t      = ref_next({8'h0, m8}, {8'h0, resp8}, 16'h00B8, 1'b1, 8);
    m8     = t[7:0];
    @(negedge clk);
    cap_en = 1'b0;
  endtask

  task automatic seed(logic [15:0] s);
    seed_load = 1'b1;
    seed_val  = s;
    seed_val8 = s[7:0];
    @(negedge clk);
    seed_load = 1'b0;
    m16 = s;
    m8  = s[7:0];
  endtask

  function automatic logic [15:0] next_word();
    lcg = lcg * 32'h0019_660D + 32'h3C6E_F35F;
    return lcg[31:16];
  endfunction

  // Replays a fixed 12-word stream, optionally flipping one bit of one word.
  task automatic run_stream(int err_word, int err_bit);
    logic [15:0] d;
    lcg = 32'h1234_5678;
    for (int k = 0; k < 12; k++) begin
      d = next_word();
      if (k == err_word) d[err_bit] = ~d[err_bit];
      capture(d);
    end
  endtask

  task automatic pulse_done();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 signature after reset", sig16, 16'h0000);
    check("R1 xnor signature after reset", {8'h0, sig8}, 16'h0000);
    check("R1 flags after reset", {14'h0, pass16, fail16}, 16'h0000);
  endtask

  task automatic t_stream();
    seed(16'hACE1);
    check("R2 seed loaded", sig16, 16'hACE1);
    lcg = 32'hCAFE_0001;
    for (int k = 0; k < 40; k++) begin
      capture(next_word());
      check("R3 R4 xor update", sig16, m16);
      check("R5 xnor update", {8'h0, sig8}, {8'h0, m8});
    end
  endtask

  task automatic t_hold();
    logic [15:0] keep16;
    logic [7:0]  keep8;
    keep16 = sig16;
    keep8  = sig8;
    for (int k = 0; k < 5; k++) begin
      resp  = next_word();
      resp8 = resp[7:0];
      @(negedge clk);
    end
    check("R6 hold without capture", sig16, keep16);
    check("R6 xnor hold without capture", {8'h0, sig8}, {8'h0, keep8});
  endtask

  task automatic t_pass(output logic [15:0] g16, output logic [7:0] g8);
    seed(16'h5A5A);
    run_stream(-1, 0);
    g16 = m16;
    g8  = m8;
    golden  = g16;
    golden8 = g8;
    pulse_done();
    check("R7 pass on match", {14'h0, pass16, fail16}, 16'h0002);
    check("R7 xnor pass on match", {14'h0, pass8, fail8}, 16'h0002);
    golden  = ~g16;
    golden8 = ~g8;
    cap_en  = 1'b1;
    resp    = 16'hFFFF;
    resp8   = 8'hFF;
    done    = 1'b1;
    repeat (3) @(negedge clk);
    cap_en = 1'b0;
    done   = 1'b0;
    check("R8 verdict held", {14'h0, pass16, fail16}, 16'h0002);
    check("R8 signature frozen", sig16, g16);
    check("R8 xnor signature frozen", {8'h0, sig8}, {8'h0, g8});
  endtask

  task automatic t_fail(logic [15:0] g16, logic [7:0] g8);
    seed(16'h5A5A);
    run_stream(4, 5);
    check("R9 faulty stream matches model", sig16, m16);
    check("R9 single-bit error changes signature", {15'h0, sig16 != g16}, 16'h0001);
    golden  = g16;
    golden8 = g8;
    pulse_done();
    check("R7 fail on mismatch", {14'h0, pass16, fail16}, 16'h0001);
  endtask

  task automatic t_repeat(logic [15:0] g16, logic [7:0] g8);
    seed(16'h5A5A);
    check("R2 seed clears verdict", {14'h0, pass16, fail16}, 16'h0000);
    run_stream(-1, 0);
    check("R9 repeat gives same signature", sig16, g16);
    check("R9 xnor repeat gives same signature", {8'h0, sig8}, {8'h0, g8});
  endtask

  task automatic t_seed_priority();
    golden = sig16;
    pulse_done();
    check("R7 pass before reseed", {14'h0, pass16, fail16}, 16'h0002);
    seed_load = 1'b1;
    seed_val  = 16'h0F0F;
    seed_val8 = 8'h3C;
    cap_en    = 1'b1;
    done      = 1'b1;
    resp      = 16'h1234;
    @(negedge clk);
    seed_load = 1'b0;
    cap_en    = 1'b0;
    done      = 1'b0;
    check("R2 seed wins over capture", sig16, 16'h0F0F);
    check("R2 xnor seed wins over capture", {8'h0, sig8}, 16'h003C);
    check("R2 seed wins over done", {14'h0, pass16, fail16}, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] g16;
    logic [7:0]  g8;
    rst_n = 1'b0;
    seed_load = 1'b0; cap_en = 1'b0; done = 1'b0;
    seed_val = '0; seed_val8 = '0; resp = '0; resp8 = '0;
    golden = '0; golden8 = '0;
    m16 = '0; m8 = '0; lcg = 32'h1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_stream();
    t_hold();
    t_pass(g16, g8);
    t_fail(g16, g8);
    t_repeat(g16, g8);
    t_seed_priority();
    finish_run();
  end
endmodule